// File: doc/BRIEF.md
# Serial ADC Configuration Register Engine

This block is the controller side of a four-wire serial link to a SAR converter that holds one 8-bit configuration register. It turns single-cycle requests from local logic into fixed 16-bit frames: an 8-bit opcode followed by an 8-bit data byte. It can read the register, write a new value to it, or change the span-compression bit through a read-modify-write that cannot be interrupted. The serial clock is made from the system clock by a parameterised divider. The link uses SPI mode 0: the clock idles low, the converter samples on the rising edge, and the engine shifts its next bit on the falling edge.

After reset the engine writes the register's power-up value on its own. A strap input chooses whether the high-impedance input bit is set in that value. Only after this first write does the engine accept requests. Each request ends with a one-cycle `done` pulse. The value most recently read or written stays visible on `shadow`.

The controller has these states. `ST_BOOT` launches the power-up write and `ST_BOOT_WAIT` waits for it to finish, then moves to `ST_IDLE`. From `ST_IDLE`, a request moves the engine to `ST_WR` (write), `ST_RD` (read) or `ST_MOD_RD` (span change). Any of these requests launches a frame in the same cycle. `ST_WR` and `ST_RD` return to `ST_IDLE` when their frame ends. `ST_MOD_RD` moves to `ST_MOD_LAUNCH` when the read frame ends. `ST_MOD_LAUNCH` starts the write-back frame and moves to `ST_MOD_WR`. `ST_MOD_WR` returns to `ST_IDLE` when that frame ends. If more than one request is raised in the same idle cycle, a span change wins over a write, and a write wins over a read.

Top module: `sar_cfg_engine`

## Requirements
- R1: A write request sends one frame of 16 bits, MSB first: opcode 0x14 in the first byte, then the requested value. `cs_n` stays low for the whole frame.
- R2: A read request sends one 16-bit frame with opcode 0x54 in the first byte. The 8 bits received on `miso` during the second byte, MSB first, appear on `rd_data`.
- R3: After reset, `busy` is high and the engine writes 0xE1 to the register without any request. Requests raised during this write are ignored.
- R4: When `hiz_sel` is high, the power-up value has bit 2 set, so 0xE5 is written.
- R5: A span request reads the register and then writes back the read value with bit 3 replaced by `span_val`, leaving all other bits unchanged. This takes exactly two frames with `busy` held high throughout.
- R6: `mosi` is high whenever `cs_n` is high.
- R7: `sck` is low whenever `cs_n` is high, and every frame contains exactly 16 rising edges of `sck`.
- R8: A request raised while `busy` is high starts no frame and changes neither the register nor `shadow`.
- R9: `done` is high for exactly one cycle when a request completes, and in that cycle `busy` is already low. The power-up write gives no `done`.
- R10: `shadow` holds the last value read from or written to the register, including the power-up value. It does not change while the engine is idle.
- R11: Each half period of `sck`, and the gap from the falling edge of `cs_n` to the first rising edge of `sck`, lasts `SCK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hiz_sel | input | 1 | Sets the high-impedance bit in the power-up value |
| rd_req | input | 1 | Read request, one cycle |
| wr_req | input | 1 | Write request, one cycle |
| wr_data | input | 8 | Value for a write request |
| span_req | input | 1 | Span-compression change request, one cycle |
| span_val | input | 1 | New value of the span-compression bit |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last value read from the register |
| shadow | output | 8 | Last value read or written |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select / convert line, active low |
| mosi | output | 1 | Serial data to the converter, idles high |
| miso | input | 1 | Serial data from the converter |

## Verification
If the controller enters the wrong state, the effect shows on the serial pins within one frame. A missing write-back or an extra frame changes the frame count and the register value held by the bench's converter model. A wrong branch out of `ST_IDLE` sends the wrong opcode, and the model rejects that frame. A shadow or done register updated in the wrong state shows on `shadow`, `rd_data` or `done` at the cycle the frame ends. Each operation in the vector table is therefore checked at its `done` pulse against the model's register and the number of frames it counted. Separate directed tests cover the power-up write, requests made while busy, and the timing of the serial clock.

// File: rtl/sar_cfg_pkg.sv
`timescale 1ns/1ps
package sar_cfg_pkg;
    localparam int REG_W    = 8;
    localparam int FRAME_W  = 2 * REG_W;
    localparam logic [REG_W-1:0] OP_WRITE = 8'h14;
    localparam logic [REG_W-1:0] OP_READ  = 8'h54;
    localparam logic [REG_W-1:0] BOOT_VAL = 8'hE1;
    localparam int HIZ_BIT  = 2;
    localparam int SPAN_BIT = 3;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_BOOT_WAIT,
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_MOD_RD,
        ST_MOD_LAUNCH,
        ST_MOD_WR
    } state_e;
endpackage

// File: rtl/sar_cfg_divider.sv
`timescale 1ns/1ps
module sar_cfg_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sar_cfg_shifter.sv
`timescale 1ns/1ps
module sar_cfg_shifter
    import sar_cfg_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    input  logic               miso,
    output logic               fr_end,
    output logic [REG_W-1:0]   rx_byte,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi
);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    logic               active;
    logic               tick;
    logic [FRAME_W-1:0] sh;
    logic [BW-1:0]      nbits;

    sar_cfg_divider #(.DIV(SCK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            sh      <= '1;
            nbits   <= '0;
            rx_byte <= '0;
            fr_end  <= 1'b0;
        end else begin
            fr_end <= 1'b0;
            if (!active && go) begin
                active <= 1'b1;
                sh     <= word;
                sck    <= 1'b0;
                nbits  <= '0;
            end else if (active && tick) begin
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[REG_W-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    sh  <= {sh[FRAME_W-2:0], 1'b1};
                    if (nbits == LAST_BIT) begin
                        active <= 1'b0;
                        fr_end <= 1'b1;
                    end else begin
                        nbits <= nbits + 1'b1;
                    end
                end
            end
        end
    end

    assign cs_n = !active;
    assign mosi = active ? sh[FRAME_W-1] : 1'b1;
endmodule

// File: rtl/sar_cfg_engine.sv
`timescale 1ns/1ps
module sar_cfg_engine
    import sar_cfg_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hiz_sel,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic [REG_W-1:0] wr_data,
    input  logic             span_req,
    input  logic             span_val,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] shadow,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    state_e             st, nxt;
    logic               go;
    logic [FRAME_W-1:0] word;
    logic               fr_end;
    logic [REG_W-1:0]   rx_byte;
    logic [REG_W-1:0]   boot_val;
    logic [REG_W-1:0]   mod_val;
    logic [REG_W-1:0]   last_tx;
    logic               span_hold;

    sar_cfg_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .word   (word),
        .miso   (miso),
        .fr_end (fr_end),
        .rx_byte(rx_byte),
        .sck    (sck),
        .cs_n   (cs_n),
        .mosi   (mosi)
    );

    always_comb begin
        boot_val          = BOOT_VAL;
        boot_val[HIZ_BIT] = hiz_sel;
        mod_val           = rx_byte;
        mod_val[SPAN_BIT] = span_hold;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_BOOT;
        else        st <= nxt;
    end

    // next state and frame launch
    always_comb begin
        nxt  = st;
        go   = 1'b0;
        word = '1;
        unique case (st)
            ST_BOOT: begin
                go   = 1'b1;
                word = {OP_WRITE, boot_val};
                nxt  = ST_BOOT_WAIT;
            end
            ST_BOOT_WAIT: if (fr_end) nxt = ST_IDLE;
            ST_IDLE: begin
                if (span_req) begin
                    go   = 1'b1;
                    word = {OP_READ, {REG_W{1'b1}}};
                    nxt  = ST_MOD_RD;
                end else if (wr_req) begin
                    go   = 1'b1;
                    word = {OP_WRITE, wr_data};
                    nxt  = ST_WR;
                end else if (rd_req) begin
                    go   = 1'b1;
                    word = {OP_READ, {REG_W{1'b1}}};
                    nxt  = ST_RD;
                end
            end
            ST_WR:     if (fr_end) nxt = ST_IDLE;
            ST_RD:     if (fr_end) nxt = ST_IDLE;
            ST_MOD_RD: if (fr_end) nxt = ST_MOD_LAUNCH;
            ST_MOD_LAUNCH: begin
                go   = 1'b1;
                word = {OP_WRITE, mod_val};
                nxt  = ST_MOD_WR;
            end
            ST_MOD_WR: if (fr_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs and data holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            rd_data   <= '0;
            shadow    <= '0;
            last_tx   <= '0;
            span_hold <= 1'b0;
        end else begin
            done <= fr_end && (st == ST_WR || st == ST_RD || st == ST_MOD_WR);
            if (go) last_tx <= word[REG_W-1:0];
            if (st == ST_IDLE && span_req) span_hold <= span_val;
            if (fr_end) begin
                unique case (st)
                    ST_RD, ST_MOD_RD: begin
                        rd_data <= rx_byte;
                        shadow  <= rx_byte;
                    end
                    ST_WR, ST_MOD_WR, ST_BOOT_WAIT: shadow <= last_tx;
                    default: ;
                endcase
            end
        end
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/sar_cfg_engine_chk.sv
`timescale 1ns/1ps
module sar_cfg_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cs_n,
    input logic       sck,
    input logic       mosi,
    input logic [7:0] shadow
);
    p_mosi_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> mosi);

    p_sck_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_frame_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_shadow_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(shadow));
endmodule

bind sar_cfg_engine sar_cfg_engine_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .cs_n  (cs_n),
    .sck   (sck),
    .mosi  (mosi),
    .shadow(shadow)
);

// File: tb/sar_cfg_engine_tb.sv
`timescale 1ns/1ps
module sar_cfg_engine_tb;
    localparam int DIV = 4;
    localparam int NV  = 10;
    // {op[1:0], data[7:0], expected[7:0]}; op 0 write, 1 read, 2 span (data[0] = bit value)
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'hC6, 8'hC6},
        {2'd1, 8'h00, 8'hC6},
        {2'd2, 8'h01, 8'hCE},
        {2'd1, 8'h00, 8'hCE},
        {2'd2, 8'h00, 8'hC6},
        {2'd0, 8'hFF, 8'hFF},
        {2'd2, 8'h00, 8'hF7},
        {2'd1, 8'h00, 8'hF7},
        {2'd0, 8'h3C, 8'h3C},
        {2'd2, 8'h01, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hiz_sel = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0, span_req = 1'b0, span_val = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, done, sck, cs_n, mosi, miso;
    logic [7:0] rd_data, shadow;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sar_cfg_engine #(.SCK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .hiz_sel(hiz_sel),
        .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
        .span_req(span_req), .span_val(span_val),
        .busy(busy), .done(done), .rd_data(rd_data), .shadow(shadow),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // converter model
    logic [7:0]  mreg = 8'h00;
    logic [15:0] rxsh = 16'h0;
    int bitc = 0, frames = 0, wr_frames = 0, rd_frames = 0, bad = 0, dcount = 0;
    realtime t_csf = 0, t_rise = 0, lead = 0, hi_len = 0;
    logic first_edge = 1'b0;
    logic [2:0] midx;

    assign midx = 3'(15 - bitc);
    assign miso = (!cs_n && bitc >= 8 && bitc < 16) ? mreg[midx] : 1'b0;

    always @(negedge cs_n) begin
        bitc = 0; rxsh = 16'h0; t_csf = $realtime; first_edge = 1'b1;
    end
    always @(posedge sck) begin
        if (!cs_n) begin
            rxsh = {rxsh[14:0], mosi};
            bitc = bitc + 1;
        end
        if (first_edge) begin
            lead = $realtime - t_csf;
            first_edge = 1'b0;
        end
        t_rise = $realtime;
    end
    always @(negedge sck) hi_len = $realtime - t_rise;
    always @(posedge cs_n) begin
        if (rst_n) begin
            frames = frames + 1;
            if (bitc != 16) bad = bad + 1;
            else if (rxsh[15:8] == 8'h14) begin mreg = rxsh[7:0]; wr_frames = wr_frames + 1; end
            else if (rxsh[15:8] == 8'h54) rd_frames = rd_frames + 1;
            else bad = bad + 1;
        end
    end
    always @(negedge clk) if (rst_n && done) dcount = dcount + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk("R9 done seen, busy low", {30'd0, done, busy}, 32'h2);
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic launch(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        case (op)
            2'd0: begin wr_req = 1'b1; wr_data = d; end
            2'd1: rd_req = 1'b1;
            default: begin span_req = 1'b1; span_val = d[0]; end
        endcase
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; span_req = 1'b0;
    endtask

    task automatic do_reset(input logic hz);
        @(negedge clk);
        rst_n = 1'b0; hiz_sel = hz;
        repeat (3) @(negedge clk);
        frames = 0; wr_frames = 0; rd_frames = 0; bad = 0; dcount = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int f0, w0;
        // R3: power-up write, requests ignored meanwhile
        do_reset(1'b0);
        @(negedge clk);
        chk("R3 busy after reset", {31'd0, busy}, 32'd1);
        repeat (20) @(negedge clk);
        wr_req = 1'b1; wr_data = 8'h22;
        @(negedge clk);
        wr_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R3 power-up value", {24'd0, mreg}, 32'hE1);
        chk("R3 single frame", frames, 1);
        chk("R9 no done on power-up", dcount, 0);
        chk("R10 shadow power-up", {24'd0, shadow}, 32'hE1);
        chk("R6 mosi idle high", {31'd0, mosi}, 32'd1);
        chk("R7 sck idle low", {30'd0, sck, cs_n}, 32'd1);
        chk("R11 cs to first edge", int'(lead), DIV * 20);
        chk("R11 sck high time", int'(hi_len), DIV * 20);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][17:16];
            f0 = frames;
            launch(op, VEC[i][15:8]);
            wait_done();
            chk((op == 2'd0) ? "R1 write frames" : (op == 2'd1) ? "R2 read frames" : "R5 span frames",
                frames - f0, (op == 2'd2) ? 2 : 1);
            chk("R10 shadow", {24'd0, shadow}, {24'd0, VEC[i][7:0]});
            if (op == 2'd1) chk("R2 rd_data", {24'd0, rd_data}, {24'd0, VEC[i][7:0]});
            else chk((op == 2'd0) ? "R1 register value" : "R5 register value",
                     {24'd0, mreg}, {24'd0, VEC[i][7:0]});
        end
        chk("R7 sixteen bits, valid opcodes", bad, 0);

        // R8: write during a read is dropped
        f0 = frames; w0 = wr_frames;
        launch(2'd1, 8'h00);
        repeat (20) @(negedge clk);
        wr_req = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_req = 1'b0;
        wait_done();
        repeat (50) @(negedge clk);
        chk("R8 no extra frame", frames - f0, 1);
        chk("R8 no write frame", wr_frames - w0, 0);
        chk("R8 register kept", {24'd0, mreg}, 32'h3C);
        chk("R8 shadow kept", {24'd0, shadow}, 32'h3C);

        // R4: high-impedance strap
        do_reset(1'b1);
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R4 power-up value with strap", {24'd0, mreg}, 32'hE5);
        chk("R4 shadow with strap", {24'd0, shadow}, 32'hE5);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule